// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a processor-side request port and a downstream PCI-style bus. Software programs three outbound windows and one packed control register through a small register port. For every request address the block checks, in the same cycle, whether the address lands in an enabled window. On a hit it produces the translated bus address, the address space (memory or I/O) and the 4-bit bus command code. On a miss it raises a miss flag.

Each window register packs three byte-wide fields: the processor base byte, a size mask and the bus-side translation byte. Windows are therefore placed and sized in 16 MB steps. The control register carries one byte per window with an enable bit, a read-command variant and a space select. The request path is purely combinational. Register writes take effect at the next clock edge. A synchronous reset clears every register, which disables all windows.

Top module: `outwin_xlate`

## Requirements
- R1: After a synchronous reset, every register reads zero and every request reports a miss.
- R2: Offsets 0x70, 0x74 and 0x78 hold windows 0, 1 and 2, and offset 0x80 holds the control register. Bits 31:8 read back as written and bits 7:0 always read zero. A write to any other offset changes nothing, and any other offset reads zero.
- R3: A window register has base byte in bits 31:24, mask in bits 23:16 and translation byte in bits 15:8. It hits when its enable is set and (addr[31:24] & ~mask) equals (base & ~mask).
- R4: On a hit, out_addr is {(xlat & ~mask) | (addr[31:24] & mask), addr[23:0]}.
- R5: When several enabled windows hit, the lowest-numbered one supplies the address, space and command.
- R6: On a miss, out_miss is 1 and out_addr, out_cmd and out_is_io are all zero.
- R7: A window's control byte sits at bits 31:24, 23:16 and 15:8 of the control register for windows 0, 1 and 2. In that byte, bit 0 enables the window and bits 2:1 pick the read command. For a memory read, 00 and 11 give 0x6, 01 gives 0xE and 10 gives 0xC.
- R8: A memory write gives command 0x7 and an I/O write gives 0x3. An I/O read gives 0x2 whatever bits 2:1 hold.
- R9: out_is_io equals bit 3 of the hitting window's control byte (1 = I/O space).
- R10: The request path is combinational. A register write changes the translation only after the clock edge that captures it.
- R11: The standard programming works. Window 0 maps 0x8000_0000–0x9FFF_FFFF as memory with read-multiple, window 1 maps 0xA000_0000–0xAFFF_FFFF as memory with plain read, and window 2 maps 0xB000_0000–0xB0FF_FFFF as I/O at bus address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at reg_addr |
| req_addr | input | 32 | Processor-side request address |
| req_write | input | 1 | Request is a write |
| out_addr | output | 32 | Translated bus address, zero on a miss |
| out_is_io | output | 1 | Hit targets I/O space |
| out_cmd | output | 4 | Bus command code, zero on a miss |
| out_miss | output | 1 | No enabled window matched |

## Verification
Every value of the upper address byte is swept for both reads and writes, first under the standard programming and then under pseudo-random window and control settings. The sweeps separate the mask from the compare, expose windows that hit at the wrong edge, and catch translation bytes taken from the wrong source. A layout with nested, overlapping windows, run both with and without the lowest window, shows whether the priority order is right. Directed probes cover each read-variant code, including the unused 11 code and variant bits on I/O windows. Further probes cover reserved readback bits and writes to unmapped offsets. One probe checks the translation just before and just after the edge that captures a control write, which shows whether a write takes effect early or late.

// File: rtl/outwin_pkg.sv
package outwin_pkg;

   localparam int FLD_W = 8;

   typedef struct packed {
      logic [FLD_W-1:0] base;
      logic [FLD_W-1:0] mask;
      logic [FLD_W-1:0] xlat;
   } win_cfg_t;

   typedef struct packed {
      logic [3:0] spare;
      logic       io;
      logic [1:0] rdsel;
      logic       en;
   } win_ctl_t;

   localparam logic [3:0] CMD_IO_RD      = 4'h2;
   localparam logic [3:0] CMD_IO_WR      = 4'h3;
   localparam logic [3:0] CMD_MEM_RD     = 4'h6;
   localparam logic [3:0] CMD_MEM_WR     = 4'h7;
   localparam logic [3:0] CMD_MEM_RDMULT = 4'hC;
   localparam logic [3:0] CMD_MEM_RDLINE = 4'hE;

   function automatic logic [3:0] pick_cmd(input logic io, input logic [1:0] rdsel,
                                           input logic wr);
      logic [3:0] c;
      if (io)
         c = wr ? CMD_IO_WR : CMD_IO_RD;
      else if (wr)
         c = CMD_MEM_WR;
      else begin
         case (rdsel)
            2'b01:   c = CMD_MEM_RDLINE;
            2'b10:   c = CMD_MEM_RDMULT;
            default: c = CMD_MEM_RD;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/outwin_regs.sv
module outwin_regs
   import outwin_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_WIN  = 3,
   parameter int OFS_W    = 8,
   parameter int WIN_OFS0 = 'h70,
   parameter int CTRL_OFS = 'h80
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           reg_wr,
   input  logic [OFS_W-1:0]               reg_addr,
   input  logic [ADDR_W-1:0]              reg_wdata,
   output logic [ADDR_W-1:0]              reg_rdata,
   output win_cfg_t [NUM_WIN-1:0]         cfg,
   output win_ctl_t [NUM_WIN-1:0]         ctl
);

   localparam int CFG_W  = 3 * FLD_W;
   localparam int PAD_W  = ADDR_W - CFG_W;
   localparam int CTL_W  = NUM_WIN * FLD_W;
   localparam int CPAD_W = ADDR_W - CTL_W;

   win_cfg_t [NUM_WIN-1:0] cfg_q;
   logic     [CTL_W-1:0]   ctl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         ctl_q <= '0;
      end else if (reg_wr) begin
         for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == OFS_W'(WIN_OFS0 + 4 * i))
               cfg_q[i] <= reg_wdata[ADDR_W-1 -: CFG_W];
         end
         if (reg_addr == OFS_W'(CTRL_OFS))
            ctl_q <= reg_wdata[ADDR_W-1 -: CTL_W];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (reg_addr == OFS_W'(WIN_OFS0 + 4 * i))
            reg_rdata = {cfg_q[i], {PAD_W{1'b0}}};
      end
      if (reg_addr == OFS_W'(CTRL_OFS))
         reg_rdata = {ctl_q, {CPAD_W{1'b0}}};
   end

   assign cfg = cfg_q;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_ctl
      assign ctl[g] = ctl_q[CTL_W-1-FLD_W*g -: FLD_W];
   end

endmodule

// File: rtl/outwin_match.sv
module outwin_match
   import outwin_pkg::*;
(
   input  win_cfg_t         cfg,
   input  win_ctl_t         ctl,
   input  logic [FLD_W-1:0] top,
   output logic             hit,
   output logic [FLD_W-1:0] xbyte
);

   logic [FLD_W-1:0] keep;

   assign keep  = ~cfg.mask;
   assign hit   = ctl.en && ((top & keep) == (cfg.base & keep));
   assign xbyte = (cfg.xlat & keep) | (top & cfg.mask);

endmodule

// File: rtl/outwin_pick.sv
module outwin_pick
   import outwin_pkg::*;
#(
   parameter int NUM_WIN = 3
) (
   input  logic     [NUM_WIN-1:0]            hit,
   input  logic     [NUM_WIN-1:0][FLD_W-1:0] xbyte,
   input  win_ctl_t [NUM_WIN-1:0]            ctl,
   output logic                              any,
   output logic     [FLD_W-1:0]              sel_x,
   output win_ctl_t                          sel_ctl
);

   assign any = |hit;

   if (NUM_WIN == 1) begin : g_single
      assign sel_x   = hit[0] ? xbyte[0] : '0;
      assign sel_ctl = hit[0] ? ctl[0]   : '0;
   end else begin : g_multi
      always_comb begin
         sel_x   = '0;
         sel_ctl = '0;
         for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
               sel_x   = xbyte[i];
               sel_ctl = ctl[i];
            end
         end
      end
   end

endmodule

// File: rtl/outwin_xlate.sv
module outwin_xlate
   import outwin_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_WIN  = 3,
   parameter int OFS_W    = 8,
   parameter int WIN_OFS0 = 'h70,
   parameter int CTRL_OFS = 'h80
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [OFS_W-1:0]  reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_is_io,
   output logic [3:0]        out_cmd,
   output logic              out_miss
);

   localparam int LOW_W = ADDR_W - FLD_W;

   if (NUM_WIN < 1 || NUM_WIN * FLD_W >= ADDR_W) begin : g_bad_num
      $error("outwin_xlate: NUM_WIN control bytes must leave a spare byte");
   end
   if (ADDR_W < 4 * FLD_W) begin : g_bad_width
      $error("outwin_xlate: ADDR_W too small for three fields and a spare byte");
   end
   if (WIN_OFS0 + 4 * NUM_WIN > CTRL_OFS) begin : g_bad_map
      $error("outwin_xlate: window registers overlap the control register");
   end
   if (CTRL_OFS >= (1 << OFS_W)) begin : g_bad_ofs
      $error("outwin_xlate: control offset does not fit OFS_W");
   end

   win_cfg_t [NUM_WIN-1:0]            cfg;
   win_ctl_t [NUM_WIN-1:0]            ctl;
   logic     [NUM_WIN-1:0]            hit;
   logic     [NUM_WIN-1:0][FLD_W-1:0] xbyte;
   logic                              any;
   logic     [FLD_W-1:0]              sel_x;
   win_ctl_t                          sel_ctl;

   outwin_regs #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .OFS_W(OFS_W),
      .WIN_OFS0(WIN_OFS0), .CTRL_OFS(CTRL_OFS)
   ) i_regs (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg), .ctl(ctl)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      outwin_match i_match (
         .cfg(cfg[g]), .ctl(ctl[g]), .top(req_addr[ADDR_W-1 -: FLD_W]),
         .hit(hit[g]), .xbyte(xbyte[g])
      );
   end

   outwin_pick #(.NUM_WIN(NUM_WIN)) i_pick (
      .hit(hit), .xbyte(xbyte), .ctl(ctl),
      .any(any), .sel_x(sel_x), .sel_ctl(sel_ctl)
   );

   assign out_miss  = !any;
   assign out_addr  = any ? {sel_x, req_addr[LOW_W-1:0]} : '0;
   assign out_is_io = any & sel_ctl.io;
   assign out_cmd   = any ? pick_cmd(sel_ctl.io, sel_ctl.rdsel, req_write) : 4'h0;

endmodule

// File: rtl/outwin_checker.sv
module outwin_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] reg_rdata,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_is_io,
   input logic [3:0]        out_cmd,
   input logic              out_miss
);

   localparam int LOW_W = ADDR_W - 8;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (reg_rdata == '0 && out_miss));

   a_r2_spare_zero: assert property (@(posedge clk) disable iff (rst)
      reg_rdata[7:0] == 8'h00);

   a_r4_low_pass: assert property (@(posedge clk) disable iff (rst)
      !out_miss |-> out_addr[LOW_W-1:0] == req_addr[LOW_W-1:0]);

   a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
      out_miss |-> (out_addr == '0 && out_cmd == 4'h0 && !out_is_io));

   a_r7_mem_read: assert property (@(posedge clk) disable iff (rst)
      (!out_miss && !out_is_io && !req_write) |->
         (out_cmd == 4'h6 || out_cmd == 4'hE || out_cmd == 4'hC));

   a_r8_write_cmd: assert property (@(posedge clk) disable iff (rst)
      (!out_miss && req_write) |-> (out_cmd == 4'h7 || out_cmd == 4'h3));

   a_r9_io_cmd: assert property (@(posedge clk) disable iff (rst)
      (!out_miss && out_is_io) |-> (out_cmd == 4'h2 || out_cmd == 4'h3));

endmodule

bind outwin_xlate outwin_checker #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .req_addr(req_addr),
   .req_write(req_write), .out_addr(out_addr), .out_is_io(out_is_io),
   .out_cmd(out_cmd), .out_miss(out_miss)
);

// File: tb/test_outwin_xlate.sv
`timescale 1ns/1ps
module test_outwin_xlate;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] out_addr;
   logic        out_is_io;
   logic [3:0]  out_cmd;
   logic        out_miss;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] m_win [3];
   logic [31:0] m_ctl;

   outwin_xlate i_outwin_xlate (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
      .req_write(req_write), .out_addr(out_addr), .out_is_io(out_is_io),
      .out_cmd(out_cmd), .out_miss(out_miss)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog actual %0d expected <150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 3; i++) m_win[i] = '0;
      m_ctl = '0;
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = ofs; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (ofs == 8'h70 || ofs == 8'h74 || ofs == 8'h78)
         m_win[(ofs - 8'h70) >> 2] = d & 32'hFFFF_FF00;
      else if (ofs == 8'h80)
         m_ctl = d & 32'hFFFF_FF00;
   endtask

   task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
      reg_addr = ofs;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [37:0] model(input logic [31:0] a, input logic w);
      logic [37:0] r;
      r = {1'b1, 37'd0};
      for (int i = 2; i >= 0; i--) begin
         logic [7:0] b, m, x, c;
         b = m_win[i][31:24]; m = m_win[i][23:16]; x = m_win[i][15:8];
         c = m_ctl[31 - 8 * i -: 8];
         if (c[0] && ((a[31:24] & ~m) == (b & ~m))) begin
            logic [3:0] cmd;
            if (c[3]) cmd = w ? 4'h3 : 4'h2;
            else if (w) cmd = 4'h7;
            else if (c[2:1] == 2'b01) cmd = 4'hE;
            else if (c[2:1] == 2'b10) cmd = 4'hC;
            else cmd = 4'h6;
            r = {1'b0, c[3], cmd, (x & ~m) | (a[31:24] & m), a[23:0]};
         end
      end
      return r;
   endfunction

   function automatic logic [37:0] obs();
      return {out_miss, out_is_io, out_cmd, out_addr};
   endfunction

   task automatic probe(input string tag, input logic [31:0] a, input logic w);
      req_addr = a; req_write = w;
      #1;
      chk(tag, 64'(obs()), 64'(model(a, w)));
   endtask

   task automatic hand(input string tag, input logic [31:0] a, input logic w,
                       input logic [37:0] exp);
      req_addr = a; req_write = w;
      #1;
      chk(tag, 64'(obs()), 64'(exp));
   endtask

   task automatic sweep(input string tag, input logic [23:0] low);
      for (int t = 0; t < 256; t++) begin
         probe(tag, {t[7:0], low}, 1'b0);
         probe(tag, {t[7:0], low}, 1'b1);
      end
   endtask

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      logic [31:0] d;
      logic [31:0] s;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      rd(8'h70, d); chk("R1 win0", 64'(d), 64'h0);
      rd(8'h74, d); chk("R1 win1", 64'(d), 64'h0);
      rd(8'h78, d); chk("R1 win2", 64'(d), 64'h0);
      rd(8'h80, d); chk("R1 ctrl", 64'(d), 64'h0);
      hand("R1 miss", 32'h0000_0000, 1'b0, {1'b1, 37'd0});
      sweep("R1 sweep", 24'h000000);

      // R2: readback and spare bits
      wr(8'h70, 32'h1234_5678);
      rd(8'h70, d); chk("R2 win0 rb", 64'(d), 64'h1234_5600);
      wr(8'h78, 32'hFEDC_BAFF);
      rd(8'h78, d); chk("R2 win2 rb", 64'(d), 64'hFEDC_BA00);
      wr(8'h80, 32'hF0F0_F0FF);
      rd(8'h80, d); chk("R2 ctrl rb", 64'(d), 64'hF0F0_F000);
      wr(8'h7C, 32'hDEAD_BEEF);
      rd(8'h7C, d); chk("R2 unmapped 7C", 64'(d), 64'h0);
      wr(8'h84, 32'hFFFF_FFFF);
      rd(8'h84, d); chk("R2 unmapped 84", 64'(d), 64'h0);
      rd(8'h70, d); chk("R2 win0 kept", 64'(d), 64'h1234_5600);
      rd(8'h74, d); chk("R2 win1 kept", 64'(d), 64'h0);
      rd(8'h78, d); chk("R2 win2 kept", 64'(d), 64'hFEDC_BA00);
      rd(8'h80, d); chk("R2 ctrl kept", 64'(d), 64'hF0F0_F000);

      // R11: standard programming
      wr(8'h70, 32'h801F_8000);
      wr(8'h74, 32'hA00F_A000);
      wr(8'h78, 32'hB000_0000);
      wr(8'h80, 32'h0501_0900);
      hand("R11 w0 rdmult", 32'h8123_4567, 1'b0, {1'b0, 1'b0, 4'hC, 32'h8123_4567});
      hand("R11 w0 top", 32'h9FFF_FFFF, 1'b0, {1'b0, 1'b0, 4'hC, 32'h9FFF_FFFF});
      hand("R11 w0 wr", 32'h8000_0000, 1'b1, {1'b0, 1'b0, 4'h7, 32'h8000_0000});
      hand("R11 w1 rd", 32'hA000_0010, 1'b0, {1'b0, 1'b0, 4'h6, 32'hA000_0010});
      hand("R11 w1 wr", 32'hAFFF_FFFF, 1'b1, {1'b0, 1'b0, 4'h7, 32'hAFFF_FFFF});
      hand("R11 w2 io rd", 32'hB012_3456, 1'b0, {1'b0, 1'b1, 4'h2, 32'h0012_3456});
      hand("R11 w2 io wr", 32'hB0FF_FFFC, 1'b1, {1'b0, 1'b1, 4'h3, 32'h00FF_FFFC});
      hand("R6 above w2", 32'hB100_0000, 1'b0, {1'b1, 37'd0});
      hand("R6 below w0", 32'h7FFF_FFFF, 1'b1, {1'b1, 37'd0});
      hand("R6 above", 32'hC000_0000, 1'b0, {1'b1, 37'd0});
      sweep("R11 sweep", 24'hA5_5A_3C);

      // R10: write takes effect only after the capturing edge
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h0;
      req_addr = 32'h8000_0040; req_write = 1'b0;
      #1;
      chk("R10 before edge", 64'(obs()), 64'({1'b0, 1'b0, 4'hC, 32'h8000_0040}));
      @(posedge clk);
      #1;
      chk("R10 after edge", 64'(obs()), 64'({1'b1, 37'd0}));
      reg_wr = 1'b0;
      m_ctl = '0;

      // R5: overlapping windows, lowest index wins
      wr(8'h70, 32'h400F_1000);
      wr(8'h74, 32'h403F_0000);
      wr(8'h78, 32'h00FF_F000);
      wr(8'h80, 32'h0103_0900);
      hand("R5 w0 wins", 32'h4512_3456, 1'b0, {1'b0, 1'b0, 4'h6, 32'h1512_3456});
      hand("R5 w1 wins", 32'h6000_0001, 1'b0, {1'b0, 1'b0, 4'hE, 32'h2000_0001});
      hand("R5 w2 only", 32'h9000_0002, 1'b0, {1'b0, 1'b1, 4'h2, 32'h9000_0002});
      sweep("R5 sweep", 24'h00_00_00);
      wr(8'h80, 32'h0003_0900);
      hand("R5 w0 off", 32'h4512_3456, 1'b0, {1'b0, 1'b0, 4'hE, 32'h0512_3456});
      sweep("R5 sweep off", 24'hFF_FF_FF);

      // R7 R8 R9: command variants
      wr(8'h70, 32'h2000_2000);
      wr(8'h74, 32'h0000_0000);
      wr(8'h78, 32'h0000_0000);
      wr(8'h80, 32'h0100_0000);
      hand("R7 rdsel 00", 32'h2000_0000, 1'b0, {1'b0, 1'b0, 4'h6, 32'h2000_0000});
      wr(8'h80, 32'h0300_0000);
      hand("R7 rdsel 01", 32'h2000_0000, 1'b0, {1'b0, 1'b0, 4'hE, 32'h2000_0000});
      wr(8'h80, 32'h0500_0000);
      hand("R7 rdsel 10", 32'h2000_0000, 1'b0, {1'b0, 1'b0, 4'hC, 32'h2000_0000});
      wr(8'h80, 32'h0700_0000);
      hand("R7 rdsel 11", 32'h2000_0000, 1'b0, {1'b0, 1'b0, 4'h6, 32'h2000_0000});
      hand("R8 mem wr", 32'h2000_0000, 1'b1, {1'b0, 1'b0, 4'h7, 32'h2000_0000});
      wr(8'h80, 32'h0D00_0000);
      hand("R8 io rd variant", 32'h2000_0000, 1'b0, {1'b0, 1'b1, 4'h2, 32'h2000_0000});
      hand("R9 io wr", 32'h2000_0000, 1'b1, {1'b0, 1'b1, 4'h3, 32'h2000_0000});
      wr(8'h80, 32'h0C00_0000);
      hand("R3 disabled", 32'h2000_0000, 1'b0, {1'b1, 37'd0});

      // R3 R4: pseudo-random configurations
      s = 32'h1357_9BDF;
      for (int k = 0; k < 8; k++) begin
         s = xs(s); wr(8'h70, s);
         s = xs(s); wr(8'h74, s);
         s = xs(s); wr(8'h78, s);
         s = xs(s); wr(8'h80, s | 32'h0101_0000);
         s = xs(s);
         sweep("R3/R4 random", s[23:0]);
      end

      // R1: reset in the middle of a run
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      model_reset();
      rd(8'h80, d); chk("R1 ctrl after rst", 64'(d), 64'h0);
      rd(8'h74, d); chk("R1 win1 after rst", 64'(d), 64'h0);
      sweep("R1 sweep after rst", 24'h12_34_56);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule